// File: doc/BRIEF.md
# On-chip SRAM power mode controller

This block chooses the power state of an on-chip SRAM macro. It looks at the current system low-power mode, whether the top power domain stays on, whether the memory has accesses waiting, and two configuration fields that software programs. From these it picks a target state: Run, Stand-by, Retention or Power-down. It drives the SRAM chip select, the peripheral power enable and the core power enable to match that state. It also reports the state on a two-bit indication.

The block never jumps straight between states. On the way down it drops chip select first, then peripheral power, then core power, one step per clock. On the way up it restores core power first and then peripheral power. It then waits a programmable settling time before it raises a ready flag, and only after that may chip select come back. A sticky flag records that the contents were lost, which happens whenever the memory leaves Power-down (SLEEP also lands in Power-down). Software clears that flag through a small register interface. The same interface holds the idle field, the stop field and the wake delay.

The state machine has five states. ST_RUN, ST_STBY, ST_RET and ST_PD are the four resting states. ST_WAKE is peripheral power settling. Its transitions are:
- RUN to STBY when the target is below Run.
- STBY to RUN when the target is Run.
- STBY to RET when the target is Retention or lower.
- RET to PD when the target is Power-down.
- RET to WAKE when the target is Stand-by or Run.
- PD to RET whenever the target is above Power-down.
- WAKE to STBY when the delay count is reached.

Top module: `sram_pwr_ctrl`

## Requirements
- R1: The mode code is 0 NORMAL, 1 IDLE, 2 DEEP-IDLE, 3 STOP, 4 DEEP-STOP, 5 SLEEP; codes 6 and 7 act as SLEEP. In NORMAL, in IDLE, and in DEEP-IDLE with top_on=1, the target is Run while access_req=1 and Stand-by otherwise. From Stand-by, Run is reached one clock after the request.
- R2: Each resting state drives these outputs, given as chip select / peripheral / core, then state_ind:
  - Run: 1/1/1, state_ind 00.
  - Stand-by: 0/1/1, state_ind 01.
  - Retention: 0/0/1, state_ind 10.
  - Power-down: 0/0/0, state_ind 11.
- R3: In DEEP-IDLE with top_on=0 the target comes from the idle field, coded 00 Stand-by, 01 Retention, 10 Power-down and 11 Power-down. access_req is ignored in this case.
- R4: In STOP and DEEP-STOP the target comes from the stop field, using the same coding.
- R5: In SLEEP (codes 5 to 7) the target is Power-down whatever the stop and idle fields hold.
- R6: Going down, chip select falls first. Peripheral power falls no earlier than one clock later. Core power falls no earlier than one clock after that.
- R7: Going up, core power rises one clock before peripheral power. ready rises wake_delay+1 clocks after peripheral power, and chip select is never high while ready is low.
- R8: contents_invalid becomes 1 when the state leaves Power-down. It stays 0 after leaving Retention or Stand-by. It holds until a write to address 3 and is 0 after reset.
- R9: The registers sit at address 0 (idle field, bits 1:0), address 1 (stop field, bits 1:0), address 2 (wake delay) and address 3 (contents_invalid in bit 0). cfg_we writes on the clock edge and cfg_rdata shows the addressed register at once.
- R10: After reset the state is Stand-by with ready=1 and contents_invalid=0. Both fields reset to 00 and the wake delay resets to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_mode | input | 3 | System low-power mode code |
| top_on | input | 1 | Top power domain stays on |
| access_req | input | 1 | Memory accesses are pending |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | WAKE_W | Register write data |
| cfg_rdata | output | WAKE_W | Register read data |
| sram_cs | output | 1 | SRAM chip select |
| peri_pwr_en | output | 1 | Peripheral power enable |
| core_pwr_en | output | 1 | Core power enable |
| state_ind | output | 2 | Current power state code |
| ready | output | 1 | Memory powered and settled |
| contents_invalid | output | 1 | Contents lost since last clear |

## Verification
Directed sequences drive the full descent from Run to Power-down and the full climb back, checked clock by clock. These show whether the one-step ordering of chip select, peripheral power and core power is kept, and whether the wake delay is counted exactly. A delay of zero is tried as well. Sequences from each mode code with the fields set to other values show whether the right field is chosen, and whether SLEEP and a DEEP-IDLE with the top domain on ignore the fields. Random mode, top-domain, access and field combinations, each left to settle, compare the resting outputs with a bench model. They also compare contents_invalid across many departures from Power-down and from Retention.

// File: rtl/sram_pwr_pkg.sv
package sram_pwr_pkg;
    typedef enum logic [1:0] {
        LVL_RUN  = 2'b00,
        LVL_STBY = 2'b01,
        LVL_RET  = 2'b10,
        LVL_PD   = 2'b11
    } lvl_t;

    typedef enum logic [2:0] {
        ST_RUN, ST_STBY, ST_RET, ST_PD, ST_WAKE
    } st_t;

    localparam logic [2:0] MD_NORMAL    = 3'd0;
    localparam logic [2:0] MD_IDLE      = 3'd1;
    localparam logic [2:0] MD_DEEP_IDLE = 3'd2;
    localparam logic [2:0] MD_STOP      = 3'd3;
    localparam logic [2:0] MD_DEEP_STOP = 3'd4;

    function automatic lvl_t field_to_lvl(input logic [1:0] f);
        unique case (f)
            2'b00:   return LVL_STBY;
            2'b01:   return LVL_RET;
            default: return LVL_PD;
        endcase
    endfunction
endpackage

// File: rtl/spc_target.sv
module spc_target
    import sram_pwr_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       top_on,
    input  logic       access_req,
    input  logic [1:0] idle_fld,
    input  logic [1:0] stop_fld,
    output lvl_t       tgt
);
    always_comb begin
        unique case (mode)
            MD_NORMAL, MD_IDLE: tgt = access_req ? LVL_RUN : LVL_STBY;
            MD_DEEP_IDLE: begin
                if (top_on) tgt = access_req ? LVL_RUN : LVL_STBY;
                else        tgt = field_to_lvl(idle_fld);
            end
            MD_STOP, MD_DEEP_STOP: tgt = field_to_lvl(stop_fld);
            default: tgt = LVL_PD; // SLEEP codes: all power removed
        endcase
    end
endmodule

// File: rtl/spc_regs.sv
module spc_regs #(
    parameter int WAKE_W   = 4,
    parameter int WAKE_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [WAKE_W-1:0] wdata,
    input  logic              inv_flag,
    output logic [WAKE_W-1:0] rdata,
    output logic [1:0]        idle_fld,
    output logic [1:0]        stop_fld,
    output logic [WAKE_W-1:0] wake_dly,
    output logic              inv_clr
);
    localparam logic [WAKE_W-1:0] DLY_RST = WAKE_W'(WAKE_RST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_fld <= 2'b00;
            stop_fld <= 2'b00;
            wake_dly <= DLY_RST;
        end else if (we) begin
            unique case (addr)
                2'd0:    idle_fld <= wdata[1:0];
                2'd1:    stop_fld <= wdata[1:0];
                2'd2:    wake_dly <= wdata;
                default: ;
            endcase
        end
    end

    assign inv_clr = we && (addr == 2'd3);

    always_comb begin
        rdata = '0;
        unique case (addr)
            2'd0:    rdata[1:0] = idle_fld;
            2'd1:    rdata[1:0] = stop_fld;
            2'd2:    rdata      = wake_dly;
            default: rdata[0]   = inv_flag;
        endcase
    end
endmodule

// File: rtl/spc_fsm.sv
module spc_fsm
    import sram_pwr_pkg::*;
#(
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lvl_t              tgt,
    input  logic [WAKE_W-1:0] wake_dly,
    input  logic              inv_clr,
    output logic              cs,
    output logic              peri,
    output logic              core,
    output logic [1:0]        ind,
    output logic              ready,
    output logic              inv
);
    st_t               st, nxt;
    logic [WAKE_W-1:0] cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN:  if (tgt != LVL_RUN) nxt = ST_STBY;
            ST_STBY: begin
                if (tgt == LVL_RUN)       nxt = ST_RUN;
                else if (tgt != LVL_STBY) nxt = ST_RET;
            end
            ST_RET: begin
                if (tgt == LVL_PD)        nxt = ST_PD;
                else if (tgt != LVL_RET)  nxt = ST_WAKE;
            end
            ST_PD:   if (tgt != LVL_PD) nxt = ST_RET;
            ST_WAKE: if (cnt >= wake_dly) nxt = ST_STBY;
            default: nxt = ST_STBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_STBY;
            cnt <= '0;
            inv <= 1'b0;
        end else begin
            st  <= nxt;
            cnt <= (st == ST_WAKE) ? cnt + 1'b1 : '0;
            if (st == ST_PD && nxt != ST_PD) inv <= 1'b1;
            else if (inv_clr)                inv <= 1'b0;
        end
    end

    always_comb begin
        unique case (st)
            ST_RUN:  begin cs = 1'b1; peri = 1'b1; core = 1'b1; ind = 2'b00; ready = 1'b1; end
            ST_STBY: begin cs = 1'b0; peri = 1'b1; core = 1'b1; ind = 2'b01; ready = 1'b1; end
            ST_RET:  begin cs = 1'b0; peri = 1'b0; core = 1'b1; ind = 2'b10; ready = 1'b0; end
            ST_PD:   begin cs = 1'b0; peri = 1'b0; core = 1'b0; ind = 2'b11; ready = 1'b0; end
            default: begin cs = 1'b0; peri = 1'b1; core = 1'b1; ind = 2'b01; ready = 1'b0; end
        endcase
    end

    // R6: chip select low before peripheral power drops; peripheral before core
    a_r6_cs_before_peri: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(peri) |-> !$past(cs));
    a_r6_peri_before_core: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core) |-> !$past(peri));
    // R7: core up before peripheral, chip select only when ready
    a_r7_core_before_peri: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(peri) |-> $past(core));
    a_r7_cs_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cs |-> ready);
    a_r7_ready_after_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(peri) && $past(core)));
    // R8: contents flag only raised on leaving power-down
    a_r8_inv_from_pd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv) |-> ($past(ind) == 2'b11));
endmodule

// File: rtl/sram_pwr_ctrl.sv
module sram_pwr_ctrl
    import sram_pwr_pkg::*;
#(
    parameter int WAKE_W   = 4,
    parameter int WAKE_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sys_mode,
    input  logic              top_on,
    input  logic              access_req,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [WAKE_W-1:0] cfg_wdata,
    output logic [WAKE_W-1:0] cfg_rdata,
    output logic              sram_cs,
    output logic              peri_pwr_en,
    output logic              core_pwr_en,
    output logic [1:0]        state_ind,
    output logic              ready,
    output logic              contents_invalid
);
    logic [1:0]        idle_fld, stop_fld;
    logic [WAKE_W-1:0] wake_dly;
    logic              inv_clr;
    lvl_t              tgt;

    spc_regs #(.WAKE_W(WAKE_W), .WAKE_RST(WAKE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .inv_flag(contents_invalid), .rdata(cfg_rdata),
        .idle_fld(idle_fld), .stop_fld(stop_fld), .wake_dly(wake_dly),
        .inv_clr(inv_clr)
    );

    spc_target u_tgt (
        .mode(sys_mode), .top_on(top_on), .access_req(access_req),
        .idle_fld(idle_fld), .stop_fld(stop_fld), .tgt(tgt)
    );

    spc_fsm #(.WAKE_W(WAKE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .wake_dly(wake_dly),
        .inv_clr(inv_clr), .cs(sram_cs), .peri(peri_pwr_en),
        .core(core_pwr_en), .ind(state_ind), .ready(ready),
        .inv(contents_invalid)
    );
endmodule

// File: tb/sim_sram_pwr_ctrl.sv
module sim_sram_pwr_ctrl;
    localparam int W = 4;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   sys_mode = 3'd0;
    logic         top_on = 1'b1, access_req = 1'b0, cfg_we = 1'b0;
    logic [1:0]   cfg_addr = 2'd0;
    logic [W-1:0] cfg_wdata = '0;
    logic [W-1:0] cfg_rdata;
    logic         sram_cs, peri_pwr_en, core_pwr_en, ready, contents_invalid;
    logic [1:0]   state_ind;
    int           total = 0, bad = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    sram_pwr_ctrl #(.WAKE_W(W), .WAKE_RST(3)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .top_on(top_on),
        .access_req(access_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sram_cs(sram_cs),
        .peri_pwr_en(peri_pwr_en), .core_pwr_en(core_pwr_en),
        .state_ind(state_ind), .ready(ready), .contents_invalid(contents_invalid)
    );

    function automatic logic [1:0] fld_lvl(input logic [1:0] f);
        return (f == 2'b00) ? 2'b01 : (f == 2'b01) ? 2'b10 : 2'b11;
    endfunction

    function automatic logic [1:0] exp_lvl(input logic [2:0] m, input logic t,
                                           input logic a, input logic [1:0] fi,
                                           input logic [1:0] fs);
        if (m <= 3'd1 || (m == 3'd2 && t)) return a ? 2'b00 : 2'b01;
        if (m == 3'd2) return fld_lvl(fi);
        if (m <= 3'd4) return fld_lvl(fs);
        return 2'b11;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // resting outputs for a level: {cs,peri,core,ready}
    task automatic chk_lvl(input string req, input logic [1:0] l);
        logic [3:0] e;
        case (l)
            2'b00:   e = 4'b1111;
            2'b01:   e = 4'b0111;
            2'b10:   e = 4'b0010;
            default: e = 4'b0000;
        endcase
        chk({req, " state_ind"}, state_ind, l);
        chk({req, " cs/peri/core/ready"},
            {sram_cs, peri_pwr_en, core_pwr_en, ready}, e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        cfg_addr = a;
        #0.5;
        chk(req, cfg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] fi, fs, l0, l1;
        logic [2:0] m;
        logic       t, a;
        void'($urandom(32'd2024));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        chk_lvl("R10 reset", 2'b01);
        chk("R10 reset inv", contents_invalid, 0);
        rd_chk("R10 idle reset", 2'd0, 0);
        rd_chk("R10 stop reset", 2'd1, 0);
        rd_chk("R10 delay reset", 2'd2, 3);

        // R1 normal/idle/deep-idle with top on
        access_req = 1'b1; tick(1);
        chk_lvl("R1 normal run", 2'b00);
        access_req = 1'b0; tick(1);
        chk_lvl("R1 normal stby", 2'b01);
        sys_mode = 3'd1; access_req = 1'b1; tick(1);
        chk_lvl("R1 idle run", 2'b00);
        sys_mode = 3'd2; top_on = 1'b1; wr(2'd0, 4'd2); tick(2);
        chk_lvl("R1 deep-idle top-on keeps run", 2'b00);

        // R9 write/read
        wr(2'd1, 4'd2);
        rd_chk("R9 stop field", 2'd1, 2);
        rd_chk("R9 idle field", 2'd0, 2);

        // R6 descent one step per edge, R4 stop field
        sys_mode = 3'd0; tick(1);
        sys_mode = 3'd3; tick(1);
        chk_lvl("R6 step1 cs off", 2'b01);
        tick(1);
        chk_lvl("R6 step2 peri off", 2'b10);
        tick(1);
        chk_lvl("R6 R4 step3 core off", 2'b11);

        // R7 wake sequence, R8 invalid after power-down
        sys_mode = 3'd0; access_req = 1'b1; tick(1);
        chk_lvl("R7 core first", 2'b10);
        tick(1);
        chk("R7 peri second", {peri_pwr_en, core_pwr_en, ready, sram_cs}, 4'b1100);
        tick(3);
        chk("R7 not ready yet", ready, 0);
        tick(1);
        chk("R7 ready at delay+1", {ready, sram_cs}, 2'b10);
        tick(1);
        chk_lvl("R7 run after ready", 2'b00);
        chk("R8 invalid after pd", contents_invalid, 1);
        rd_chk("R9 R8 flag readback", 2'd3, 1);
        wr(2'd3, 4'd0);
        chk("R8 cleared by write", contents_invalid, 0);

        // R4 deep-stop retention, R8 stays clear
        wr(2'd1, 4'd1);
        sys_mode = 3'd4; tick(4);
        chk_lvl("R4 deep-stop retention", 2'b10);
        sys_mode = 3'd0; tick(12);
        chk_lvl("R8 back to run", 2'b00);
        chk("R8 clear after retention", contents_invalid, 0);

        // R3 idle field with top off, access ignored
        wr(2'd0, 4'd0);
        sys_mode = 3'd2; top_on = 1'b0; tick(3);
        chk_lvl("R3 idle stby ignores access", 2'b01);
        wr(2'd0, 4'd3); tick(3);
        chk_lvl("R3 idle code 11 power-down", 2'b11);

        // R5 sleep ignores fields
        wr(2'd1, 4'd0); wr(2'd0, 4'd0);
        sys_mode = 3'd5; tick(4);
        chk_lvl("R5 sleep pd", 2'b11);
        sys_mode = 3'd7; tick(2);
        chk_lvl("R5 code 7 pd", 2'b11);

        // R7 zero delay
        wr(2'd2, 4'd0);
        sys_mode = 3'd0; access_req = 1'b0; tick(1);
        chk_lvl("R7 d0 core", 2'b10);
        tick(1);
        chk("R7 d0 peri not ready", {peri_pwr_en, ready}, 2'b10);
        tick(1);
        chk_lvl("R7 d0 ready next", 2'b01);
        wr(2'd2, 4'd3);
        wr(2'd3, 4'd0);

        // random settled checks
        for (int i = 0; i < 40; i++) begin
            fi = 2'($urandom_range(0, 3));
            fs = 2'($urandom_range(0, 3));
            wr(2'd0, {2'b00, fi});
            wr(2'd1, {2'b00, fs});
            tick(25);
            l0 = exp_lvl(sys_mode, top_on, access_req, fi, fs);
            chk_lvl("R1 R3 R4 R5 random settle", l0);
            wr(2'd3, 4'd0);
            m = 3'($urandom_range(0, 7));
            t = 1'($urandom_range(0, 1));
            a = 1'($urandom_range(0, 1));
            sys_mode = m; top_on = t; access_req = a;
            tick(25);
            l1 = exp_lvl(m, t, a, fi, fs);
            chk_lvl("R2 random mode", l1);
            chk("R8 random invalid", contents_invalid,
                (l0 == 2'b11 && l1 != 2'b11) ? 1 : 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule